// File: doc/BRIEF.md
# Turn-by-Turn Capture and Freeze Buffer

This block keeps a history of per-turn sample records for one beam. Each record packs two oscillation values, horizontal and vertical, with four electrode amplitudes. A turn strobe writes one record into an inferred RAM at the full turn rate, so nothing is skipped on the way in. Each beam has its own independent instance of the block.

The block has two recording modes, chosen when it is armed. In capture mode the block waits for a trigger, then stores a programmed number of turns and stops. In freeze mode recording starts at arm time and runs around the circular buffer without stopping until a trigger freezes it.

Once recording has stopped, a readout request returns the most recent turns, oldest first, ending at the stop point. Readout can skip turns by an integer decimation factor. The status outputs report whether the block is armed, recording or done, whether the buffer has wrapped, and the final write pointer.

Top module: `tbt_turn_buffer`

## Requirements
- R1: After reset, st_armed, st_recording, st_done, st_wrapped and rd_valid are 0 and st_wptr is 0.
- R2: A stored record is returned on rd_data as {osc_in, amp_in}, with osc_in in the upper 2*SAMPLE_W bits. osc_in holds {vertical, horizontal} and amp_in holds four amplitudes.
- R3: Arming with freeze_mode=0 gives armed and not recording. A later trigger starts recording. The next cap_turns strobes are written at consecutive addresses from 0, then done rises and st_wptr equals cap_turns mod DEPTH. A strobe in the trigger cycle is not stored.
- R4: In capture mode, a trigger with cap_turns=0 sets done at once and writes nothing.
- R5: Arming with freeze_mode=1 starts recording at once, and every strobe is written with wrap modulo DEPTH. A trigger stops recording and sets done. A strobe in the trigger cycle is not stored.
- R6: st_wrapped rises after a write to address DEPTH-1, and arm clears it.
- R7: A readout of rd_turns returns the last n=min(rd_turns, turns written since arm, capped at DEPTH) records, oldest first, ending just before st_wptr.
- R8: With decimation D (a value of 0 counts as 1), readout returns the oldest selected record and then every D-th one, ceil(n/D) records in all. rd_last marks the final record.
- R9: rd_start is ignored unless the block is done and no readout is running. A request that resolves to n=0 returns nothing.
- R10: A trigger is ignored when the block is not armed, including after done and in capture mode while recording. Strobes are ignored when the block is not recording.
- R11: Arm clears done, wrapped and the write pointer, aborts any readout, and wins over a trigger in the same cycle.
- R12: rd_valid is only high while done is high, and done and recording are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| turn_strobe | input | 1 | One pulse per turn, with sample data valid |
| osc_in | input | 2*SAMPLE_W | {vertical, horizontal} oscillation samples |
| amp_in | input | 4*SAMPLE_W | Four electrode amplitudes |
| freeze_mode | input | 1 | Mode taken at arm: 1 freeze, 0 capture |
| arm | input | 1 | Restart pulse |
| trigger | input | 1 | Start (capture) or stop (freeze) pulse |
| cap_turns | input | CAP_W | Number of turns stored in capture mode |
| rd_start | input | 1 | Readout request pulse |
| rd_turns | input | $clog2(DEPTH+1) | Number of turns requested |
| rd_decim | input | DEC_W | Readout decimation factor |
| rd_valid | output | 1 | rd_data holds a record |
| rd_last | output | 1 | Final record of this readout |
| rd_data | output | 6*SAMPLE_W | Record read out |
| st_armed | output | 1 | Waiting for trigger or recording |
| st_recording | output | 1 | Strobes are being stored |
| st_done | output | 1 | Recording has stopped |
| st_wrapped | output | 1 | Buffer has wrapped since arm |
| st_wptr | output | $clog2(DEPTH) | Next write address, and the final pointer once done |

## Verification
The assertions check several properties on every cycle. Done and recording are never high together. Readout data appears only while done is high, and rd_last never appears without rd_valid. The write pointer stays put whenever the block is not recording. Each arm returns the status to a clean state on the following cycle. The bench scenarios are needed for the rest: record contents and their order, the start address of the readout window, wrap-around, clamping to the fill level, decimation counts, and the mode-specific meaning of a trigger. A bench model of the memory checks these.

// File: rtl/tbt_pkg.sv
package tbt_pkg;
  typedef enum logic [1:0] {
    REC_IDLE = 2'd0,
    REC_WAIT = 2'd1,
    REC_RUN  = 2'd2,
    REC_DONE = 2'd3
  } rec_state_t;
endpackage

// File: rtl/tbt_ram.sv
module tbt_ram #(
  parameter int DW    = 144,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tbt_rec_ctrl.sv
module tbt_rec_ctrl
  import tbt_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int CAP_W = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             freeze_mode,
  input  logic             trigger,
  input  logic             strobe,
  input  logic [CAP_W-1:0] cap_turns,
  output logic             we,
  output logic [AW-1:0]    wptr,
  output logic [FW-1:0]    fill,
  output logic             wrapped,
  output rec_state_t       state
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [FW-1:0] FULL      = FW'(DEPTH);

  logic             mode_q;
  logic [CAP_W-1:0] cnt, limit;
  logic             stop_now;

  assign stop_now = (state == REC_RUN) && trigger && mode_q;
  assign we       = (state == REC_RUN) && strobe && !arm && !stop_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= REC_IDLE;
      mode_q  <= 1'b0;
      wptr    <= '0;
      fill    <= '0;
      wrapped <= 1'b0;
      cnt     <= '0;
      limit   <= '0;
    end else if (arm) begin
      mode_q  <= freeze_mode;
      wptr    <= '0;
      fill    <= '0;
      wrapped <= 1'b0;
      cnt     <= '0;
      state   <= freeze_mode ? REC_RUN : REC_WAIT;
    end else begin
      unique case (state)
        REC_WAIT: if (trigger) begin
          limit <= cap_turns;
          cnt   <= '0;
          state <= (cap_turns == '0) ? REC_DONE : REC_RUN;
        end
        REC_RUN: if (stop_now) begin
          state <= REC_DONE;
        end else if (we) begin
          wptr <= (wptr == LAST_ADDR) ? '0 : wptr + 1'b1;
          if (wptr == LAST_ADDR) wrapped <= 1'b1;
          if (fill != FULL) fill <= fill + 1'b1;
          if (!mode_q) begin
            cnt <= cnt + 1'b1;
            if (cnt + 1'b1 == limit) state <= REC_DONE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tbt_rd_ctrl.sv
module tbt_rd_ctrl #(
  parameter int DEPTH = 64,
  parameter int DEC_W = 8,
  parameter int AW    = $clog2(DEPTH),
  parameter int FW    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             abort,
  input  logic             start_ok,
  input  logic             rd_start,
  input  logic [FW-1:0]    rd_turns,
  input  logic [DEC_W-1:0] rd_decim,
  input  logic [FW-1:0]    fill,
  input  logic [AW-1:0]    wptr,
  output logic             ram_re,
  output logic [AW-1:0]    ram_ra,
  output logic             vld,
  output logic             last
);
  localparam int MW = ((FW > DEC_W) ? FW : DEC_W) + 1;
  localparam int NW = ((AW > DEC_W) ? AW : DEC_W) + 1;
  localparam logic [AW+1:0] DEPTH_X = (AW+2)'(DEPTH);
  localparam logic [NW-1:0] DEPTH_N = NW'(DEPTH);

  logic             busy;
  logic [AW-1:0]    cur, sa, nxt;
  logic [MW-1:0]    rem;
  logic [DEC_W-1:0] step, dstep;
  logic [FW-1:0]    n;
  logic [AW+1:0]    n_x, wp_x;
  logic [NW-1:0]    sum;
  logic             is_last;

  always_comb begin
    n     = (rd_turns < fill) ? rd_turns : fill;
    dstep = (rd_decim == '0) ? DEC_W'(1) : rd_decim;
    n_x   = (AW+2)'(n);
    wp_x  = (AW+2)'(wptr);
    sa    = (n_x > wp_x) ? AW'(wp_x + DEPTH_X - n_x) : AW'(wp_x - n_x);
    sum   = NW'(cur) + NW'(step);
    nxt   = (sum >= DEPTH_N) ? AW'(sum - DEPTH_N) : AW'(sum);
    is_last = (rem <= MW'(step));
  end

  assign ram_re = busy;
  assign ram_ra = cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      vld  <= 1'b0;
      last <= 1'b0;
      cur  <= '0;
      rem  <= '0;
      step <= DEC_W'(1);
    end else begin
      vld  <= busy && !abort;
      last <= busy && !abort && is_last;
      if (abort) begin
        busy <= 1'b0;
      end else if (busy) begin
        if (is_last) busy <= 1'b0;
        cur <= nxt;
        rem <= rem - MW'(step);
      end else if (rd_start && start_ok && (n != '0)) begin
        busy <= 1'b1;
        cur  <= sa;
        rem  <= MW'(n);
        step <= dstep;
      end
    end
  end
endmodule

// File: rtl/tbt_turn_buffer.sv
module tbt_turn_buffer
  import tbt_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int DEPTH    = 64,
  parameter int CAP_W    = 16,
  parameter int DEC_W    = 8,
  localparam int AW      = $clog2(DEPTH),
  localparam int FW      = $clog2(DEPTH + 1),
  localparam int REC_W   = 6 * SAMPLE_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  turn_strobe,
  input  logic [2*SAMPLE_W-1:0] osc_in,
  input  logic [4*SAMPLE_W-1:0] amp_in,
  input  logic                  freeze_mode,
  input  logic                  arm,
  input  logic                  trigger,
  input  logic [CAP_W-1:0]      cap_turns,
  input  logic                  rd_start,
  input  logic [FW-1:0]         rd_turns,
  input  logic [DEC_W-1:0]      rd_decim,
  output logic                  rd_valid,
  output logic                  rd_last,
  output logic [REC_W-1:0]      rd_data,
  output logic                  st_armed,
  output logic                  st_recording,
  output logic                  st_done,
  output logic                  st_wrapped,
  output logic [AW-1:0]         st_wptr
);
  rec_state_t    state;
  logic          we, re;
  logic [AW-1:0] ra;
  logic [FW-1:0] fill;

  tbt_rec_ctrl #(.DEPTH(DEPTH), .CAP_W(CAP_W)) u_rec (
    .clk(clk), .rst(rst), .arm(arm), .freeze_mode(freeze_mode),
    .trigger(trigger), .strobe(turn_strobe), .cap_turns(cap_turns),
    .we(we), .wptr(st_wptr), .fill(fill), .wrapped(st_wrapped), .state(state)
  );

  assign st_armed     = (state == REC_WAIT) || (state == REC_RUN);
  assign st_recording = (state == REC_RUN);
  assign st_done      = (state == REC_DONE);

  tbt_rd_ctrl #(.DEPTH(DEPTH), .DEC_W(DEC_W)) u_rd (
    .clk(clk), .rst(rst), .abort(arm), .start_ok(st_done),
    .rd_start(rd_start), .rd_turns(rd_turns), .rd_decim(rd_decim),
    .fill(fill), .wptr(st_wptr), .ram_re(re), .ram_ra(ra),
    .vld(rd_valid), .last(rd_last)
  );

  tbt_ram #(.DW(REC_W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(we), .waddr(st_wptr), .wdata({osc_in, amp_in}),
    .re(re), .raddr(ra), .rdata(rd_data)
  );
endmodule

// File: rtl/tbt_turn_buffer_chk.sv
module tbt_turn_buffer_chk #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst,
  input logic          arm,
  input logic          rd_valid,
  input logic          rd_last,
  input logic          st_recording,
  input logic          st_done,
  input logic          st_wrapped,
  input logic [AW-1:0] st_wptr
);
  // R12
  excl_state_chk: assert property (@(posedge clk) disable iff (rst)
    !(st_done && st_recording));

  // R12
  rd_when_done_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> st_done);

  // R8
  last_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |-> rd_valid);

  // R11
  rearm_clear_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!st_done && !st_wrapped && st_wptr == '0 && !rd_valid));

  // R10
  wptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!st_recording && !arm) |=> $stable(st_wptr));

  // R3
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_done && !arm) |=> st_done);
endmodule

bind tbt_turn_buffer tbt_turn_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .rd_valid(rd_valid), .rd_last(rd_last),
  .st_recording(st_recording), .st_done(st_done), .st_wrapped(st_wrapped),
  .st_wptr(st_wptr)
);

// File: tb/tb_tbt_turn_buffer.sv
module tb_tbt_turn_buffer;
  localparam int SW    = 16;
  localparam int DEPTH = 16;
  localparam int CAP_W = 8;
  localparam int DEC_W = 4;
  localparam int AW    = $clog2(DEPTH);
  localparam int FW    = $clog2(DEPTH + 1);
  localparam int RW    = 6 * SW;

  logic clk = 0, rst = 1;
  logic turn_strobe = 0, freeze_mode = 0, arm = 0, trigger = 0, rd_start = 0;
  logic [2*SW-1:0] osc_in = '0;
  logic [4*SW-1:0] amp_in = '0;
  logic [CAP_W-1:0] cap_turns = '0;
  logic [FW-1:0] rd_turns = '0;
  logic [DEC_W-1:0] rd_decim = '0;
  logic rd_valid, rd_last, st_armed, st_recording, st_done, st_wrapped;
  logic [RW-1:0] rd_data;
  logic [AW-1:0] st_wptr;

  tbt_turn_buffer #(.SAMPLE_W(SW), .DEPTH(DEPTH), .CAP_W(CAP_W), .DEC_W(DEC_W)) dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  logic [RW-1:0] m_mem [DEPTH];
  int m_state = 0, m_mode = 0, m_wptr = 0, m_fill = 0, m_cnt = 0, m_lim = 0;
  logic m_wrapped = 0;

  task automatic check(input logic ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // one cycle of stimulus; the model follows the requirements
  task automatic step(input logic s, input logic t, input logic a, input logic fm, input int cap);
    logic [RW-1:0] rec;
    osc_in = {$urandom, $urandom} ; amp_in = {$urandom, $urandom};
    rec = {osc_in, amp_in};
    turn_strobe = s; trigger = t; arm = a; freeze_mode = fm; cap_turns = CAP_W'(cap);
    tick();
    turn_strobe = 0; trigger = 0; arm = 0;
    if (a) begin
      m_wptr = 0; m_fill = 0; m_wrapped = 0; m_cnt = 0; m_mode = fm;
      m_state = fm ? 2 : 1;
    end else if (m_state == 1) begin
      if (t) begin m_lim = cap; m_cnt = 0; m_state = (cap == 0) ? 3 : 2; end
    end else if (m_state == 2) begin
      if (t && m_mode == 1) m_state = 3;
      else if (s) begin
        m_mem[m_wptr] = rec;
        if (m_wptr == DEPTH - 1) m_wrapped = 1;
        m_wptr = (m_wptr + 1) % DEPTH;
        if (m_fill < DEPTH) m_fill++;
        if (m_mode == 0) begin m_cnt++; if (m_cnt == m_lim) m_state = 3; end
      end
    end
  endtask

  task automatic chk_status(input string tag);
    check(st_armed == (m_state == 1 || m_state == 2), {tag, " armed"}, 128'(st_armed), 128'(m_state == 1 || m_state == 2));
    check(st_recording == (m_state == 2), {tag, " recording"}, 128'(st_recording), 128'(m_state == 2));
    check(st_done == (m_state == 3), {tag, " done"}, 128'(st_done), 128'(m_state == 3));
    check(st_wrapped == m_wrapped, {tag, " wrapped"}, 128'(st_wrapped), 128'(m_wrapped));
    check(int'(st_wptr) == m_wptr, {tag, " wptr"}, 128'(st_wptr), 128'(m_wptr));
  endtask

  task automatic do_read(input int turns, input int decim, input string tag);
    int n, d, sa, nexp, got;
    n = (turns < m_fill) ? turns : m_fill;
    d = (decim == 0) ? 1 : decim;
    nexp = (m_state == 3 && n != 0) ? (n + d - 1) / d : 0;
    sa = (m_wptr + DEPTH - n) % DEPTH;
    rd_start = 1; rd_turns = FW'(turns); rd_decim = DEC_W'(decim);
    tick();
    rd_start = 0;
    got = 0;
    for (int c = 0; c < 2 * DEPTH + 8; c++) begin
      tick();
      if (rd_valid) begin
        if (got < nexp) begin
          check(rd_data == m_mem[(sa + got * d) % DEPTH], {tag, " data"},
                128'(rd_data), 128'(m_mem[(sa + got * d) % DEPTH]));
          check(rd_last == (got == nexp - 1), {tag, " last"}, 128'(rd_last), 128'(got == nexp - 1));
        end
        got++;
      end
    end
    check(got == nexp, {tag, " count"}, 128'(got), 128'(nexp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk_status("R1");
    check(!rd_valid, "R1 rd_valid", 128'(rd_valid), 0);
    // R9 readout before any recording is ignored
    do_read(4, 1, "R9 early");
    // R10 trigger and strobes ignored while idle
    step(1, 1, 0, 0, 3); step(1, 0, 0, 0, 3);
    chk_status("R10 idle");
    // R3 capture
    step(0, 0, 1, 0, 5);
    chk_status("R3 armed");
    step(1, 0, 0, 0, 5); step(1, 0, 0, 0, 5);
    chk_status("R10 strobe before trigger");
    step(1, 1, 0, 0, 5);
    chk_status("R3 trigger");
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 5);
    chk_status("R3 capture done");
    // R2 R7 readout of the full window
    do_read(5, 1, "R2 R7 full");
    do_read(3, 2, "R8 decim2");
    do_read(30, 1, "R7 clamp");
    do_read(5, 0, "R8 decim0");
    // R10 trigger after done ignored
    step(1, 1, 0, 0, 5); step(1, 0, 0, 0, 5);
    chk_status("R10 after done");
    // R4 cap zero
    step(0, 0, 1, 0, 0); step(0, 1, 0, 0, 0);
    chk_status("R4 cap0");
    do_read(4, 1, "R4 R9 empty");
    // R5 R6 freeze with wrap
    step(0, 0, 1, 1, 0);
    chk_status("R5 armed");
    for (int i = 0; i < 60; i++) step(i % 3 != 2, 0, 0, 1, 0);
    chk_status("R6 wrapped");
    step(1, 1, 0, 1, 0);
    chk_status("R5 frozen");
    do_read(16, 3, "R8 decim3");
    do_read(20, 1, "R7 clamp depth");
    do_read(7, 5, "R8 decim5");
    // R7 freeze short: fill limited
    step(0, 0, 1, 1, 0);
    for (int i = 0; i < 5; i++) step(1, 0, 0, 1, 0);
    step(0, 1, 0, 1, 0);
    chk_status("R5 short");
    do_read(10, 1, "R7 fill limit");
    // R11 arm aborts readout
    rd_start = 1; rd_turns = FW'(5); rd_decim = '0;
    tick(); rd_start = 0; tick(); tick();
    step(0, 0, 1, 0, 4);
    for (int i = 0; i < 6; i++) begin
      check(!rd_valid, "R11 abort", 128'(rd_valid), 0);
      tick();
    end
    // R11 arm wins over trigger
    chk_status("R11 rearm");
    step(0, 1, 1, 0, 4);
    chk_status("R11 arm beats trigger");
    // R3 R6 capture longer than depth
    step(0, 1, 0, 0, 20);
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 20);
    chk_status("R3 R6 long capture");
    do_read(16, 1, "R7 long capture");
    // random rounds
    for (int r = 0; r < 12; r++) begin
      int fm, cap, ns;
      fm = $urandom_range(0, 1);
      cap = $urandom_range(0, 25);
      ns = $urandom_range(0, 40);
      step(0, 0, 1, 1'(fm), cap);
      if (fm == 0) step(0, 1, 0, 0, cap);
      for (int i = 0; i < ns; i++) step(1'($urandom_range(0, 1)), 0, 0, 1'(fm), cap);
      if (fm == 1) step(1'($urandom_range(0, 1)), 1, 0, 1, cap);
      chk_status("R3 R5 random");
      do_read($urandom_range(0, 20), $urandom_range(0, 6), "R7 R8 random");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule